// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a block of words between one peripheral and memory without the CPU touching each word. The CPU programs a start address, a word count and a control word with a direction bit and a start bit, using a device select, a two-bit register index and separate read and write strobes. Once started, the engine waits for the peripheral to ask for service. It then asks the CPU for the memory bus and waits for the grant. Under grant it places the current address on the memory address lines and pulses a memory read or a memory write. In the same cycle it acknowledges the peripheral, which supplies or takes the data word directly.

After each word the address moves up by one and the count moves down by one. The bus is kept between words only while the peripheral holds its request; otherwise it is handed back and asked for again later. When the count reaches zero the bus is released and an interrupt is raised. The interrupt stays up until the CPU reads the status or writes the control word. While the bus is granted, the register port answers nothing.

Top module: `dma_engine`

## Requirements
- R1: With cpu_sel and cpu_wr high, index 0 writes the address, 1 the count and 2 the control word; with cpu_rd, index 0 reads the address, 1 the count, 2 the status (bit 2 busy, bit 1 interrupt, bit 0 direction), and 3 reads zero. After reset all of these read zero. Address and count writes are ignored while a block is in progress.
- R2: Control bit 0 starts a block and bit 1 sets the direction: 1 moves memory to the peripheral using memory reads, 0 moves peripheral data into memory using memory writes.
- R3: After a start with a nonzero count, bus_req rises only once dev_req has been seen high.
- R4: A word moves in a cycle where mem_rd or mem_wr (never both) is high together with dev_ack, with bus_gnt and bus_req high and mem_addr equal to the current address. Exactly count words move per block.
- R5: After each word the address register has increased by one and the count has decreased by one.
- R6: If dev_req is still high and words remain, the next word moves without bus_req dropping.
- R7: If dev_req is low when a word moves and words remain, bus_req drops in the next cycle and is raised again when the request returns.
- R8: After the last word, bus_req is low and irq is high in the next cycle, the count reads zero, and no memory location past the block is touched.
- R9: irq stays high until a status read or a control write clears it.
- R10: A start with a zero count raises irq in the next cycle and performs no memory cycle.
- R11: While bus_gnt is high, register reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Device select for register access |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_reg | input | 2 | Register index |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data, zero when not reading |
| dev_req | input | 1 | Peripheral service request |
| dev_ack | output | 1 | Peripheral acknowledge, one per word |
| bus_req | output | 1 | Memory bus request to the CPU |
| bus_gnt | input | 1 | Memory bus grant from the CPU |
| mem_addr | output | 16 | Memory address, zero outside a word cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| irq | output | 1 | Block-complete interrupt |

## Verification
Blocks are run with four peripheral request patterns. A request held high for the whole block shows whether the bus stays granted across a burst. A request dropped after every acknowledge shows that the bus is released and asked for again once per word. A random on/off request with a randomly delayed grant mixes both cases. A request held low after start provides a busy window in which register writes must have no effect. Both directions are run, along with zero, one and longer counts. The memory after the last word and the final register values show whether the engine moved one word too many or too few.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REQ   = 2'd2,
    ST_XFER  = 2'd3
  } seq_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_DIR_BIT   = 1;

  localparam int STAT_DIR_BIT  = 0;
  localparam int STAT_IRQ_BIT  = 1;
  localparam int STAT_BUSY_BIT = 2;
endpackage

// File: rtl/dma_seq.sv
module dma_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_cmd,
  input  logic cnt_zero,
  input  logic cnt_last,
  input  logic dev_req,
  input  logic bus_gnt,
  output logic bus_req,
  output logic busy,
  output logic xfer,
  output logic finish
);
  import dma_pkg::*;

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    xfer    = 1'b0;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_cmd) begin
          if (cnt_zero) finish = 1'b1;
          else          state_d = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (dev_req) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (bus_gnt) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (bus_gnt) begin
          xfer = 1'b1;
          if (cnt_last) begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end else if (!dev_req) begin
            state_d = ST_ARMED;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign bus_req = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          xfer,
  input  logic          finish,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          irq_q,
  output logic [DW-1:0] rdata
);
  import dma_pkg::*;

  localparam logic [AW-1:0] ADDR_STEP = AW'(1);
  localparam logic [CW-1:0] CNT_STEP  = CW'(1);

  logic          addr_en, cnt_en, dir_en, irq_en;
  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic          dir_d, irq_d, irq_clr;

  always_comb begin
    addr_en = xfer || (wr_en && !busy && reg_sel == SEL_ADDR);
    addr_d  = xfer ? addr_q + ADDR_STEP : wdata[AW-1:0];
    cnt_en  = xfer || (wr_en && !busy && reg_sel == SEL_CNT);
    cnt_d   = xfer ? cnt_q - CNT_STEP : wdata[CW-1:0];
    dir_en  = wr_en && !busy && reg_sel == SEL_CTRL;
    dir_d   = wdata[CTRL_DIR_BIT];
    irq_clr = (wr_en || rd_en) && reg_sel == SEL_CTRL;
    irq_en  = finish || irq_clr;
    irq_d   = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (dir_en)  dir_q  <= dir_d;
      if (irq_en)  irq_q  <= irq_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (reg_sel)
        SEL_ADDR: rdata[AW-1:0] = addr_q;
        SEL_CNT:  rdata[CW-1:0] = cnt_q;
        SEL_CTRL: begin
          rdata[STAT_DIR_BIT]  = dir_q;
          rdata[STAT_IRQ_BIT]  = irq_q;
          rdata[STAT_BUSY_BIT] = busy;
        end
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_reg,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dev_req,
  output logic          dev_ack,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          irq
);
  import dma_pkg::*;

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          wr_en, rd_en, start_cmd;
  logic          busy, xfer, finish;
  logic          cnt_zero, cnt_last;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q;

  assign wr_en     = cpu_sel && cpu_wr && !bus_gnt;
  assign rd_en     = cpu_sel && cpu_rd && !bus_gnt;
  assign start_cmd = wr_en && !busy && cpu_reg == SEL_CTRL && cpu_wdata[CTRL_START_BIT];
  assign cnt_zero  = (cnt_q == '0);
  assign cnt_last  = (cnt_q == CNT_ONE);

  dma_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_cmd (start_cmd),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .dev_req   (dev_req),
    .bus_gnt   (bus_gnt),
    .bus_req   (bus_req),
    .busy      (busy),
    .xfer      (xfer),
    .finish    (finish)
  );

  dma_regs #(.AW(AW), .CW(CW), .DW(DW)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .reg_sel (cpu_reg),
    .wdata   (cpu_wdata),
    .busy    (busy),
    .xfer    (xfer),
    .finish  (finish),
    .addr_q  (addr_q),
    .cnt_q   (cnt_q),
    .dir_q   (dir_q),
    .irq_q   (irq),
    .rdata   (cpu_rdata)
  );

  assign mem_addr = xfer ? addr_q : '0;
  assign mem_rd   = xfer && dir_q;
  assign mem_wr   = xfer && !dir_q;
  assign dev_ack  = xfer;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_sel,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic [1:0]    cpu_reg,
  input logic          dev_req,
  input logic          dev_ack,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          irq,
  input logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic strobe, irq_clear;
  assign strobe    = mem_rd || mem_wr;
  assign irq_clear = cpu_sel && !bus_gnt && (cpu_rd || cpu_wr) && cpu_reg == 2'd2;

  a_r4_strobe_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe || dev_ack) |-> (bus_gnt && bus_req));
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r4_ack_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack == strobe);
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (cnt_q == $past(cnt_q) - ONE));
  a_r6_burst_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && dev_req && cnt_q != ONE) |=> bus_req);
  a_r7_release_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !dev_req && cnt_q != ONE) |=> !bus_req);
  a_r8_last_word_done: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && cnt_q == ONE) |=> (!bus_req && irq));
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear) |=> irq);
endmodule

bind dma_engine dma_engine_chk #(.CW(CW)) i_chk (.*);

// File: tb/test_dma_engine.sv
`timescale 1ns/1ps
module test_dma_engine;
  localparam real CLK_HALF = 10.0;

  logic        clk, rst_n;
  logic        cpu_sel, cpu_rd, cpu_wr;
  logic [1:0]  cpu_reg;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        dev_req, dev_ack, bus_req, bus_gnt;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, irq;

  dma_engine i_dma_engine (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq)
  );

  int checks = 0, fails = 0;
  logic [15:0] mem [0:255];
  logic [15:0] got [0:31];
  int widx, dev_left, strobes, rises, cur_mode, cur_salt;
  bit req_prev, done_flag;

  initial begin
    clk = 1'b0;
    forever #(CLK_HALF) clk = ~clk;
  end

  function automatic logic [15:0] mem_init(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {~b, b};
  endfunction

  function automatic logic [15:0] dev_word(input int salt, input int k);
    return 16'(32'h3C00 + salt * 273 + k * 19);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Peripheral, memory and bus arbiter model: samples first, then drives.
  initial begin
    bit acked;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        acked = 1'b0;
        if (mem_wr && dev_ack) begin
          mem[mem_addr[7:0]] = dev_word(cur_salt, widx);
          widx++; dev_left--; acked = 1'b1;
        end
        if (mem_rd && dev_ack) begin
          if (widx < 32) got[widx] = mem[mem_addr[7:0]];
          widx++; dev_left--; acked = 1'b1;
        end
        if (mem_rd || mem_wr) strobes++;
        if (bus_req && !req_prev) rises++;
        req_prev = bus_req;
        bus_gnt  = bus_req && (bus_gnt || ($urandom % 3 == 0));
        case (cur_mode)
          0: dev_req = dev_left > 0;
          1: dev_req = (dev_left > 0) && ($urandom % 2 == 1);
          3: dev_req = (dev_left > 0) && !acked;
          default: dev_req = 1'b0;
        endcase
      end
    end
  end

  task automatic cpu_write(input logic [1:0] r, input logic [15:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_reg = r; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  task automatic cpu_read(input logic [1:0] r, output logic [15:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_rd = 1'b1; cpu_reg = r;
    #2 d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      if (irq) break;
    end
    @(negedge clk);
  endtask

  task automatic prep(input int n, input int mode, input int salt);
    for (int a = 0; a < 256; a++) mem[a] = mem_init(a);
    widx = 0; strobes = 0; rises = 0;
    dev_left = n; cur_mode = mode; cur_salt = salt;
  endtask

  task automatic check_block(input int start, input int n, input bit dir, input int salt);
    logic [15:0] v;
    chk(strobes == n, "R4 word count", strobes, n);
    for (int i = 0; i < n; i++) begin
      if (dir) chk(got[i] == mem_init(start + i), "R2 R4 mem-to-dev word", got[i], mem_init(start + i));
      else     chk(mem[start + i] == dev_word(salt, i), "R2 R4 dev-to-mem word", mem[start + i], dev_word(salt, i));
    end
    chk(mem[(start + n) % 256] == mem_init((start + n) % 256), "R8 no word past block",
        mem[(start + n) % 256], mem_init((start + n) % 256));
    chk(irq == 1'b1 && bus_req == 1'b0, "R8 irq up bus free", {irq, bus_req}, 2'b10);
    cpu_read(2'd0, v);
    chk(v == 16'(start + n), "R5 final address", v, start + n);
    cpu_read(2'd1, v);
    chk(v == 16'd0, "R8 count zero", v, 0);
  endtask

  task automatic run_block(input int start, input int n, input bit dir, input int mode,
                           input int salt, input bit clr_ctrl);
    logic [15:0] v;
    prep(n, mode, salt);
    cpu_write(2'd0, 16'(start));
    cpu_write(2'd1, 16'(n));
    cpu_write(2'd2, {14'd0, dir, 1'b1});
    wait_irq();
    check_block(start, n, dir, salt);
    if (mode == 0) chk(rises == 1, "R6 single bus session", rises, 1);
    if (mode == 3) chk(rises == n, "R7 one session per word", rises, n);
    if (clr_ctrl) begin
      repeat (5) @(negedge clk);
      chk(irq == 1'b1, "R9 irq held", irq, 1);
      cpu_write(2'd2, 16'd0);
      #1 chk(irq == 1'b0, "R9 cleared by control write", irq, 0);
    end else begin
      cpu_read(2'd2, v);
      chk(v == {13'd0, 1'b0, 1'b1, dir}, "R1 R9 status", v, {13'd0, 1'b0, 1'b1, dir});
      #1 chk(irq == 1'b0, "R9 cleared by status read", irq, 0);
    end
  endtask

  initial begin
    #(CLK_HALF * 2 * 190000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cpu_sel = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_reg = '0; cpu_wdata = '0;
    dev_req = 1'b0; bus_gnt = 1'b0; cur_mode = 2; dev_left = 0; cur_salt = 0;
    widx = 0; strobes = 0; rises = 0; req_prev = 1'b0; done_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk(bus_req == 0 && irq == 0 && mem_rd == 0 && mem_wr == 0 && dev_ack == 0,
        "R1 reset outputs", {bus_req, irq, mem_rd, mem_wr, dev_ack}, 0);
    cpu_read(2'd0, v); chk(v == 0, "R1 reset address", v, 0);
    cpu_read(2'd2, v); chk(v == 0, "R1 reset status", v, 0);

    // register readback
    cpu_write(2'd0, 16'h00A5);
    cpu_write(2'd1, 16'h0033);
    cpu_read(2'd0, v); chk(v == 16'h00A5, "R1 address readback", v, 16'h00A5);
    cpu_read(2'd1, v); chk(v == 16'h0033, "R1 count readback", v, 16'h0033);
    cpu_read(2'd3, v); chk(v == 0, "R1 index 3 reads zero", v, 0);

    // directed blocks
    run_block(16'h10, 6, 1'b0, 0, 1, 1'b0);
    run_block(16'h40, 9, 1'b1, 3, 2, 1'b1);
    run_block(16'h60, 1, 1'b1, 0, 3, 1'b0);
    run_block(16'h20, 5, 1'b0, 3, 4, 1'b0);

    // zero count start
    prep(0, 0, 5);
    cpu_write(2'd1, 16'd0);
    cpu_write(2'd2, 16'h0001);
    chk(irq == 1'b1, "R10 zero count irq next cycle", irq, 1);
    repeat (10) @(negedge clk);
    chk(strobes == 0 && rises == 0, "R10 no bus cycle", strobes + rises, 0);
    cpu_write(2'd2, 16'd0);

    // writes while busy are ignored; R3 no bus request before peripheral asks
    prep(3, 2, 6);
    cpu_write(2'd0, 16'h0080);
    cpu_write(2'd1, 16'd3);
    cpu_write(2'd2, 16'h0001);
    cpu_write(2'd0, 16'h1234);
    cpu_write(2'd1, 16'h0077);
    repeat (6) @(negedge clk);
    chk(rises == 0 && bus_req == 1'b0, "R3 no request before peripheral", rises, 0);
    cur_mode = 0;
    wait_irq();
    check_block(16'h80, 3, 1'b0, 6);
    cpu_write(2'd2, 16'd0);

    // reads under grant return zero
    prep(20, 0, 7);
    cpu_write(2'd0, 16'h0090);
    cpu_write(2'd1, 16'd20);
    cpu_write(2'd2, 16'h0003);
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); #3;
      if (mem_rd || mem_wr) break;
    end
    cpu_sel = 1'b1; cpu_rd = 1'b1; cpu_reg = 2'd0;
    #1 chk(cpu_rdata == 16'd0 && bus_gnt == 1'b1, "R11 read under grant", cpu_rdata, 0);
    cpu_sel = 1'b0; cpu_rd = 1'b0;
    wait_irq();
    check_block(16'h90, 20, 1'b1, 7);
    cpu_write(2'd2, 16'd0);

    // constrained random blocks
    for (int t = 0; t < 8; t++) begin
      int st, n, md;
      bit dr;
      st = $urandom % 200;
      n  = 1 + $urandom % 12;
      dr = 1'($urandom % 2);
      md = ($urandom % 3 == 0) ? 3 : 32'($urandom % 2);
      run_block(st, n, dr, md, 10 + t, 1'($urandom % 2));
    end

    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule